// File: doc/BRIEF.md
# Byte/Word Data Pointer Pair

This block holds two data-memory address pointers for a small processor core. Each pointer is stored as a 17-bit value. A per-pointer view bit decides which 16 of those bits act as the pointer: the upper sixteen form a word address, and the lower sixteen form a byte address. Loads, readback and automatic stepping all act on the active 16-bit field. The one bit outside that field is never touched. Changing the view bit therefore reinterprets the stored 17 bits rather than rescaling them.

Instruction decode drives one access per cycle. An access is either a read or a write, and it names the target pointer and a step code.

- For a read, memory sees the current address, and the pointer moves afterwards (post-step).
- For a write, the pointer moves first, and memory sees the moved address in the same cycle (pre-step).

A software load of either pointer can arrive in the same cycle as an access, and the load wins over the automatic update. A separate readback select shows the active field of either pointer.

Each pointer cell chooses one of three update kinds every cycle:

- UPD_HOLD: the pointer keeps its value.
- UPD_LOAD: the pointer takes the load value.
- UPD_STEP: the pointer takes its stepped value.

The transitions are fixed. Load enable moves to UPD_LOAD. Otherwise, an access aimed at the cell moves to UPD_STEP. In every other case the cell takes UPD_HOLD.

The address output follows one of three access kinds:

- ACC_IDLE: the output shows the selected pointer's current field.
- ACC_READ: the output shows the same current field.
- ACC_WRITE: the output shows the selected pointer's pre-stepped field.

Top module: `dual_data_ptr`

## Requirements
- R1: After reset both pointers hold 17'h00000, so addr_o and rdbk_o read 0000h.
- R2: With view bit 1 (word), a pointer's active field is stored bits 16:1. With view bit 0 (byte), the active field is bits 15:0. rdbk_o shows the active field of the pointer named by rdbk_sel_i.
- R3: Raising ld_en_i[k] writes ld_val_i into pointer k's active field at the clock edge, and the inactive bit is left unchanged.
- R4: step_i encodes the step: 01 increments, 10 decrements, and 00 or 11 leave the pointer as it is. Arithmetic is modulo 2^16 on the active field only. A byte-view increment from FFFFh gives 0000h with bit 16 kept. A word-view step never alters bit 0.
- R5: Changing a view bit alters only the reading of the stored bits. The stored bits themselves are not modified.
- R6: During a read access, addr_o equals the selected pointer's field before the step, and the stepped value is stored at the clock edge.
- R7: During a write access, addr_o equals the selected pointer's field after the step in that same cycle, and that value is stored at the edge.
- R8: A load of the accessed pointer in the same cycle overrides its step. The access address in that cycle is still the one given by R6 or R7.
- R9: An access steps only the pointer named by acc_sel_i, and the other pointer keeps its value.
- R10: With no access, addr_o shows the active field of the pointer named by acc_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | NUM_PTR | Per-pointer view bit, 1 = word, 0 = byte |
| ld_en_i | input | NUM_PTR | Per-pointer load enable |
| ld_val_i | input | ADDR_W | Load value for the active field |
| rd_en_i | input | 1 | Read access strobe |
| wr_en_i | input | 1 | Write access strobe |
| acc_sel_i | input | SEL_W | Pointer used by the access and by addr_o |
| step_i | input | 2 | Step code: 01 increment, 10 decrement, else none |
| rdbk_sel_i | input | SEL_W | Pointer shown on rdbk_o |
| rdbk_o | output | ADDR_W | Active field of the readback pointer |
| addr_o | output | ADDR_W | Data-memory address |

## Verification
The assertions take for granted that the read and write strobes are never high together. They also take for granted that acc_sel_i names an existing pointer, so every property treats an access as purely pre-step or purely post-step. The stimulus issues at most one access per cycle and uses only the two pointer indices. It still changes the view bits freely between and during accesses, because the stepping properties compare fields under the view that was in force in the cycle of the access.

// File: rtl/dptr_pkg.sv
`timescale 1ns/1ps
package dptr_pkg;

    // Step code carried on step_i
    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_RSVD = 2'b11
    } step_e;

    // Which 16 of the 17 stored bits act as the pointer
    typedef enum logic {
        VIEW_BYTE = 1'b0,
        VIEW_WORD = 1'b1
    } view_e;

    // Per-cell update chosen each cycle
    typedef enum logic [1:0] {
        UPD_HOLD = 2'b00,
        UPD_LOAD = 2'b01,
        UPD_STEP = 2'b10
    } upd_e;

    // Kind of access presented this cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } acc_e;

endpackage

// File: rtl/dptr_view.sv
`timescale 1ns/1ps
module dptr_view
    import dptr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W:0]   raw_i,
    input  view_e             view_i,
    output logic [ADDR_W-1:0] field_o
);

    // Select the active 16-bit window out of the stored value
    always_comb begin
        unique case (view_i)
            VIEW_WORD: field_o = raw_i[ADDR_W:1];
            VIEW_BYTE: field_o = raw_i[ADDR_W-1:0];
        endcase
    end

endmodule

// File: rtl/dptr_merge.sv
`timescale 1ns/1ps
module dptr_merge
    import dptr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              keep_top_i,
    input  logic              keep_bot_i,
    input  view_e             view_i,
    input  logic [ADDR_W-1:0] field_i,
    output logic [ADDR_W:0]   raw_o
);

    // Place a new active field back, keeping the bit outside the window
    always_comb begin
        unique case (view_i)
            VIEW_WORD: raw_o = {field_i, keep_bot_i};
            VIEW_BYTE: raw_o = {keep_top_i, field_i};
        endcase
    end

endmodule

// File: rtl/dptr_cell.sv
`timescale 1ns/1ps
module dptr_cell
    import dptr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  view_e             view_i,
    input  logic              ld_en_i,
    input  logic [ADDR_W-1:0] ld_val_i,
    input  logic              step_req_i,
    input  step_e             dir_i,
    output logic [ADDR_W:0]   raw_o,
    output logic [ADDR_W-1:0] cur_o,
    output logic [ADDR_W-1:0] next_o
);

    localparam logic [ADDR_W-1:0] ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W:0]   ZERO = '0;

    logic [ADDR_W:0]   raw_q;
    logic [ADDR_W-1:0] cur_f;
    logic [ADDR_W-1:0] step_f;
    logic [ADDR_W:0]   step_raw;
    logic [ADDR_W:0]   load_raw;
    upd_e              upd;

    dptr_view #(.ADDR_W(ADDR_W)) u_view (
        .raw_i   (raw_q),
        .view_i  (view_i),
        .field_o (cur_f)
    );

    // Step acts on the active field only: wraps inside 16 bits
    always_comb begin
        unique case (dir_i)
            STEP_INC:             step_f = cur_f + ONE;
            STEP_DEC:             step_f = cur_f - ONE;
            STEP_NONE, STEP_RSVD: step_f = cur_f;
        endcase
    end

    dptr_merge #(.ADDR_W(ADDR_W)) u_step_merge (
        .keep_top_i (raw_q[ADDR_W]),
        .keep_bot_i (raw_q[0]),
        .view_i     (view_i),
        .field_i    (step_f),
        .raw_o      (step_raw)
    );

    dptr_merge #(.ADDR_W(ADDR_W)) u_load_merge (
        .keep_top_i (raw_q[ADDR_W]),
        .keep_bot_i (raw_q[0]),
        .view_i     (view_i),
        .field_i    (ld_val_i),
        .raw_o      (load_raw)
    );

    // Load outranks the automatic step
    always_comb begin
        if (ld_en_i) begin
            upd = UPD_LOAD;
        end else if (step_req_i) begin
            upd = UPD_STEP;
        end else begin
            upd = UPD_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= ZERO;
        end else begin
            unique case (upd)
                UPD_LOAD: raw_q <= load_raw;
                UPD_STEP: raw_q <= step_raw;
                UPD_HOLD: raw_q <= raw_q;
                default:  raw_q <= raw_q;
            endcase
        end
    end

    assign raw_o  = raw_q;
    assign cur_o  = cur_f;
    assign next_o = step_f;

endmodule

// File: rtl/dual_data_ptr.sv
`timescale 1ns/1ps
module dual_data_ptr
    import dptr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned NUM_PTR = 2,
    parameter int unsigned SEL_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PTR-1:0] mode_i,
    input  logic [NUM_PTR-1:0] ld_en_i,
    input  logic [ADDR_W-1:0]  ld_val_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [SEL_W-1:0]   acc_sel_i,
    input  logic [1:0]         step_i,
    input  logic [SEL_W-1:0]   rdbk_sel_i,
    output logic [ADDR_W-1:0]  rdbk_o,
    output logic [ADDR_W-1:0]  addr_o
);

    logic [ADDR_W:0]   ptr_raw [NUM_PTR];
    logic [ADDR_W-1:0] cur_f   [NUM_PTR];
    logic [ADDR_W-1:0] next_f  [NUM_PTR];
    acc_e              acc;
    step_e             dir;

    assign dir = step_e'(step_i);

    // Write takes precedence if both strobes are ever raised together
    always_comb begin
        if (wr_en_i) begin
            acc = ACC_WRITE;
        end else if (rd_en_i) begin
            acc = ACC_READ;
        end else begin
            acc = ACC_IDLE;
        end
    end

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
        logic hit;
        assign hit = (acc != ACC_IDLE) && (acc_sel_i == SEL_W'(k));

        dptr_cell #(.ADDR_W(ADDR_W)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .view_i     (view_e'(mode_i[k])),
            .ld_en_i    (ld_en_i[k]),
            .ld_val_i   (ld_val_i),
            .step_req_i (hit),
            .dir_i      (dir),
            .raw_o      (ptr_raw[k]),
            .cur_o      (cur_f[k]),
            .next_o     (next_f[k])
        );
    end

    // Post-step on read: current field; pre-step on write: moved field
    always_comb begin
        unique case (acc)
            ACC_WRITE:         addr_o = next_f[acc_sel_i];
            ACC_READ, ACC_IDLE: addr_o = cur_f[acc_sel_i];
            default:           addr_o = cur_f[acc_sel_i];
        endcase
    end

    assign rdbk_o = cur_f[rdbk_sel_i];

endmodule

// File: rtl/dual_data_ptr_chk.sv
`timescale 1ns/1ps
module dual_data_ptr_chk #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned NUM_PTR = 2,
    parameter int unsigned SEL_W   = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_PTR-1:0] mode_i,
    input logic [NUM_PTR-1:0] ld_en_i,
    input logic [ADDR_W-1:0]  ld_val_i,
    input logic               rd_en_i,
    input logic               wr_en_i,
    input logic [SEL_W-1:0]   acc_sel_i,
    input logic [1:0]         step_i,
    input logic [ADDR_W-1:0]  addr_o,
    input logic [ADDR_W:0]    ptr_raw [NUM_PTR]
);

    function automatic logic [ADDR_W-1:0] view_of(input logic [ADDR_W:0] r, input logic m);
        return m ? r[ADDR_W:1] : r[ADDR_W-1:0];
    endfunction

    // Input rule: one access kind per cycle
    p_one_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && wr_en_i));

    p_read_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !wr_en_i) |->
        (addr_o == view_of(ptr_raw[acc_sel_i], mode_i[acc_sel_i])));

    p_write_inc_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !rd_en_i && step_i == 2'b01) |->
        (addr_o == ADDR_W'(view_of(ptr_raw[acc_sel_i], mode_i[acc_sel_i]) + ADDR_W'(1))));

    p_idle_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_i && !wr_en_i) |->
        (addr_o == view_of(ptr_raw[acc_sel_i], mode_i[acc_sel_i])));

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_chk
        p_load_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ld_en_i[k] |=>
            (view_of(ptr_raw[k], $past(mode_i[k])) == $past(ld_val_i)));

        p_byte_keeps_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_i[k] |=> (ptr_raw[k][ADDR_W] == $past(ptr_raw[k][ADDR_W])));

        p_word_keeps_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            mode_i[k] |=> (ptr_raw[k][0] == $past(ptr_raw[k][0])));

        p_post_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en_i && !wr_en_i && acc_sel_i == SEL_W'(k) && step_i == 2'b01 && !ld_en_i[k]) |=>
            (view_of(ptr_raw[k], $past(mode_i[k])) ==
             ADDR_W'(view_of($past(ptr_raw[k]), $past(mode_i[k])) + ADDR_W'(1))));

        p_untouched_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_en_i[k] && !((rd_en_i || wr_en_i) && acc_sel_i == SEL_W'(k))) |=>
            $stable(ptr_raw[k]));
    end

endmodule

bind dual_data_ptr dual_data_ptr_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_PTR (NUM_PTR),
    .SEL_W   (SEL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .ld_en_i   (ld_en_i),
    .ld_val_i  (ld_val_i),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .acc_sel_i (acc_sel_i),
    .step_i    (step_i),
    .addr_o    (addr_o),
    .ptr_raw   (ptr_raw)
);

// File: tb/dual_data_ptr_tb_top.sv
`timescale 1ns/1ps
module dual_data_ptr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  ld_en_i = '0;
    logic [15:0] ld_val_i = '0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        acc_sel_i = 1'b0;
    logic [1:0]  step_i = '0;
    logic        rdbk_sel_i = 1'b0;
    logic [15:0] rdbk_o;
    logic [15:0] addr_o;

    always #2.5 clk = ~clk;

    dual_data_ptr dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .ld_en_i    (ld_en_i),
        .ld_val_i   (ld_val_i),
        .rd_en_i    (rd_en_i),
        .wr_en_i    (wr_en_i),
        .acc_sel_i  (acc_sel_i),
        .step_i     (step_i),
        .rdbk_sel_i (rdbk_sel_i),
        .rdbk_o     (rdbk_o),
        .addr_o     (addr_o)
    );

    typedef struct {
        string       tag;
        logic [15:0] addr;
        logic [15:0] rdbk;
    } sb_item_t;

    sb_item_t    sb_q [$];
    event        sample_ev;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 0;
    logic [16:0] m_raw [2];

    function automatic logic [15:0] f_view(input logic [16:0] r, input logic m);
        return m ? r[16:1] : r[15:0];
    endfunction

    function automatic logic [16:0] f_put(input logic [16:0] r, input logic m, input logic [15:0] v);
        return m ? {v, r[0]} : {r[16], v};
    endfunction

    function automatic logic [15:0] f_bump(input logic [15:0] v, input logic [1:0] s);
        case (s)
            2'b01:   return v + 16'd1;
            2'b10:   return v - 16'd1;
            default: return v;
        endcase
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Driver: apply one cycle of stimulus, queue the expected outputs
    task automatic drive(input logic [1:0] md, input logic [1:0] ld, input logic [15:0] lv,
                         input logic rd, input logic wr, input logic sel,
                         input logic [1:0] st, input logic rs, input string tag);
        logic [15:0] cur;
        logic [15:0] moved;
        @(negedge clk);
        mode_i = md; ld_en_i = ld; ld_val_i = lv;
        rd_en_i = rd; wr_en_i = wr; acc_sel_i = sel; step_i = st; rdbk_sel_i = rs;
        cur   = f_view(m_raw[sel], md[sel]);
        moved = f_bump(cur, st);
        sb_q.push_back('{tag, (wr ? moved : cur), f_view(m_raw[rs], md[rs])});
        #1 -> sample_ev;
        for (int k = 0; k < 2; k++) begin
            if (ld[k]) begin
                m_raw[k] = f_put(m_raw[k], md[k], lv);
            end else if ((rd || wr) && (sel == k[0])) begin
                m_raw[k] = f_put(m_raw[k], md[k], moved);
            end
        end
    endtask

    // Monitor: pop expected items and compare against the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks += 2;
                if (addr_o !== it.addr) begin
                    failures++;
                    $display("FAIL %s addr_o actual=%h expected=%h", it.tag, addr_o, it.addr);
                end
                if (rdbk_o !== it.rdbk) begin
                    failures++;
                    $display("FAIL %s rdbk_o actual=%h expected=%h", it.tag, rdbk_o, it.rdbk);
                end
            end
        end
    end

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        m_raw[0] = '0;
        m_raw[1] = '0;
        repeat (3) @(negedge clk);
        sb_q.push_back('{"R1", 16'h0000, 16'h0000});
        #1 -> sample_ev;
        @(negedge clk);
        rst_n = 1'b1;

        drive(2'b00, 2'b00, 16'h0000, 0, 0, 1, 2'b00, 1, "R1");
        drive(2'b00, 2'b01, 16'h1234, 0, 0, 0, 2'b00, 0, "R3");
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 0, 2'b00, 0, "R3");
        drive(2'b01, 2'b00, 16'h0000, 0, 0, 0, 2'b00, 0, "R5");   // word view 091A
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 0, 2'b00, 0, "R5");   // back to 1234
        drive(2'b10, 2'b10, 16'hFFFF, 0, 0, 1, 2'b00, 1, "R3");
        drive(2'b10, 2'b00, 16'h0000, 0, 0, 1, 2'b00, 1, "R2");
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 1, 2'b00, 1, "R2");   // byte view FFFE
        drive(2'b00, 2'b00, 16'h0000, 1, 0, 1, 2'b01, 1, "R6");
        drive(2'b00, 2'b00, 16'h0000, 1, 0, 1, 2'b01, 1, "R6");
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 1, 2'b00, 1, "R4");   // wrapped to 0000
        drive(2'b10, 2'b00, 16'h0000, 0, 0, 1, 2'b00, 1, "R4");   // bit 16 kept: 8000
        drive(2'b10, 2'b00, 16'h0000, 0, 1, 1, 2'b10, 1, "R7");   // pre-dec 7FFF
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 1, 2'b00, 1, "R4");   // bit 0 kept: FFFE
        drive(2'b00, 2'b00, 16'h0000, 1, 0, 0, 2'b10, 1, "R6");
        drive(2'b00, 2'b00, 16'h0000, 0, 1, 0, 2'b01, 0, "R7");
        drive(2'b00, 2'b00, 16'h0000, 0, 1, 0, 2'b00, 0, "R7");
        drive(2'b00, 2'b01, 16'hABCD, 1, 0, 0, 2'b01, 0, "R8");
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 0, 2'b00, 0, "R8");
        drive(2'b00, 2'b01, 16'h5555, 0, 1, 0, 2'b10, 0, "R8");
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 0, 2'b00, 0, "R8");
        drive(2'b00, 2'b00, 16'h0000, 1, 0, 0, 2'b11, 0, "R4");
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 0, 2'b00, 0, "R4");
        drive(2'b00, 2'b00, 16'h0000, 1, 0, 1, 2'b01, 0, "R9");
        drive(2'b00, 2'b00, 16'h0000, 0, 1, 1, 2'b10, 0, "R9");
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 1, 2'b00, 0, "R10");
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 0, 2'b00, 1, "R10");
        drive(2'b01, 2'b01, 16'hFFFF, 0, 0, 0, 2'b00, 0, "R3");
        drive(2'b01, 2'b00, 16'h0000, 1, 0, 0, 2'b01, 0, "R4");   // word FFFF wraps
        drive(2'b00, 2'b00, 16'h0000, 0, 0, 0, 2'b00, 0, "R4");   // byte view 0001
        drive(2'b11, 2'b00, 16'h0000, 0, 0, 0, 2'b00, 1, "R2");

        @(negedge clk);
        #2;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
        end
        report();
    end

endmodule